// File: doc/BRIEF.md
# Interrupt-to-TIC Delay Capture

This block measures how long it takes from a real-time-clock interrupt to the next TIC pulse. An interrupt pulse starts a counter from zero. The counter advances by one on each cycle in which the slow timebase tick enable is high. The first TIC pulse after the interrupt latches the count into a 16-bit result register and raises a status flag. The TIC comes either from the internal source or from an external TIC input, chosen by a select pin. Each count stands for one timebase tick. In the target timebase one tick is 2.275 µs. The result is therefore valid from zero up to the TIC period divided by the tick length, with an uncertainty of one tick.

The latched result is protected. While the status flag is set, further TICs and interrupts cannot touch it. Software consumes the result with a read strobe, which clears the flag and leaves the value readable. A global measurement-reset write strobe also clears the flag, and it aborts any measurement that is in progress.

Control is a three-state machine:
- `ST_IDLE` waits for an interrupt. The transition *arm* leads to `ST_COUNT`.
- `ST_COUNT` counts ticks. It has three transitions:
  - *rearm*: a further interrupt restarts the count at zero and stays in `ST_COUNT`.
  - *capture*: the selected TIC latches the count and leads to `ST_HELD`.
  - *abort*: a measurement reset returns to `ST_IDLE`.
- `ST_HELD` holds the result. The transition *consume* (read strobe) or *flush* (measurement reset) returns to `ST_IDLE`.

Top module: `rtc_tic_delay`

## Requirements
- R1: After reset the result `delay_q` is 0 and `meas_valid` is 0.
- R2: The captured value equals the number of cycles with `tick_en` high strictly after the interrupt cycle and strictly before the TIC cycle. A tick in the same cycle as the interrupt or the TIC is not counted.
- R3: With `tic_sel`=0 only `tic_int` captures; with `tic_sel`=1 only `tic_ext` captures. The deselected TIC input has no effect.
- R4: A TIC with no pending interrupt leaves `delay_q` unchanged and `meas_valid` at 0.
- R5: A capture sets `meas_valid` to 1 in the cycle after the TIC.
- R6: While `meas_valid` is 1, TIC, interrupt and tick inputs leave `delay_q` and `meas_valid` unchanged.
- R7: `rd_stb` while `meas_valid` is 1 clears `meas_valid` on the next cycle. `delay_q` keeps its value.
- R8: `meas_rst` clears `meas_valid` on the next cycle in any state. It also aborts a measurement in progress, so a later TIC captures nothing.
- R9: The count saturates at 0xFFFF when no TIC arrives.
- R10: An interrupt during a measurement in progress restarts the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timebase tick enable, one count per high cycle |
| irq_pulse | input | 1 | Real-time-clock interrupt pulse |
| tic_int | input | 1 | Internal TIC pulse |
| tic_ext | input | 1 | External TIC pulse |
| tic_sel | input | 1 | TIC source select: 0 internal, 1 external |
| rd_stb | input | 1 | Result read strobe |
| meas_rst | input | 1 | Global measurement-reset write strobe |
| delay_q | output | 16 | Latched delay in tick units |
| meas_valid | output | 1 | Interrupt seen and result captured, not yet consumed |

## Verification
The bench builds the block with its default 16-bit counter width, `CNT_W` = 16. This keeps the real result width under test. It also brings the saturation point within reach with a run of about 70,000 tick cycles, well inside the cycle budget. All other cases use short directed pulse patterns. These cover coincident tick/interrupt/TIC edges, source selection, re-arming and aborting.

// File: rtl/rtc_tic_delay_pkg.sv
package rtc_tic_delay_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HELD  = 2'd2
    } cap_state_e;
endpackage

// File: rtl/tic_src_mux.sv
module tic_src_mux #(
    parameter int N_SRC = 2,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] tic_vec,
    input  logic [SEL_W-1:0] sel,
    output logic             tic
);
    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = tic_vec[g] && (sel == SEL_W'(g));
    end

    assign tic = |hit;
endmodule

// File: rtl/tick_sat_counter.sv
module tick_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_tic_delay.sv
module rtc_tic_delay
    import rtc_tic_delay_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             irq_pulse,
    input  logic             tic_int,
    input  logic             tic_ext,
    input  logic             tic_sel,
    input  logic             rd_stb,
    input  logic             meas_rst,
    output logic [CNT_W-1:0] delay_q,
    output logic             meas_valid
);
    cap_state_e       state, state_nx;
    logic             tic_hit;
    logic             cnt_clr, cnt_inc, do_capture;
    logic [CNT_W-1:0] count;

    tic_src_mux #(.N_SRC(2)) u_tic_mux (
        .tic_vec ({tic_ext, tic_int}),
        .sel     (tic_sel),
        .tic     (tic_hit)
    );

    tick_sat_counter #(.W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (meas_rst)       state_nx = ST_IDLE;
                else if (irq_pulse) state_nx = ST_COUNT;   // arm
            end
            ST_COUNT: begin
                if (meas_rst)     state_nx = ST_IDLE;      // abort
                else if (tic_hit) state_nx = ST_HELD;      // capture
                else              state_nx = ST_COUNT;     // count / rearm
            end
            ST_HELD: begin
                if (meas_rst || rd_stb) state_nx = ST_IDLE; // flush / consume
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        do_capture = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_clr = irq_pulse && !meas_rst;
            end
            ST_COUNT: begin
                do_capture = tic_hit && !meas_rst;
                cnt_clr    = irq_pulse && !tic_hit;
                cnt_inc    = tick_en && !irq_pulse && !tic_hit;
            end
            ST_HELD: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          delay_q <= '0;
        else if (do_capture) delay_q <= count;
    end

    assign meas_valid = (state == ST_HELD);
endmodule

// File: rtl/rtc_tic_delay_chk.sv
module rtc_tic_delay_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tic_int,
    input logic             tic_ext,
    input logic             tic_sel,
    input logic             rd_stb,
    input logic             meas_rst,
    input logic [CNT_W-1:0] delay_q,
    input logic             meas_valid
);
    // R6
    held_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && !rd_stb && !meas_rst) |=> (meas_valid && $stable(delay_q)));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && rd_stb) |=> !meas_valid);

    // R8
    mrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_rst |=> !meas_valid);

    // R5
    set_on_tic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_valid) |-> $past(tic_sel ? tic_ext : tic_int));

    // R4
    update_only_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(delay_q) |-> $rose(meas_valid));
endmodule

bind rtc_tic_delay rtc_tic_delay_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tic_int    (tic_int),
    .tic_ext    (tic_ext),
    .tic_sel    (tic_sel),
    .rd_stb     (rd_stb),
    .meas_rst   (meas_rst),
    .delay_q    (delay_q),
    .meas_valid (meas_valid)
);

// File: tb/test_rtc_tic_delay.sv
module test_rtc_tic_delay;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 0, irq_pulse = 0, tic_int = 0, tic_ext = 0, tic_sel = 0;
    logic rd_stb = 0, meas_rst = 0;
    logic [W-1:0] delay_q;
    logic meas_valid;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_tic_delay #(.CNT_W(W)) i_rtc_tic_delay (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .irq_pulse(irq_pulse),
        .tic_int(tic_int), .tic_ext(tic_ext), .tic_sel(tic_sel),
        .rd_stb(rd_stb), .meas_rst(meas_rst),
        .delay_q(delay_q), .meas_valid(meas_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock cycle with the given inputs, ends at the following negedge
    task automatic cyc(input logic i, input logic ti, input logic te,
                       input logic tk, input logic rd, input logic mr);
        irq_pulse = i; tic_int = ti; tic_ext = te; tick_en = tk; rd_stb = rd; meas_rst = mr;
        @(negedge clk);
        irq_pulse = 0; tic_int = 0; tic_ext = 0; tick_en = 0; rd_stb = 0; meas_rst = 0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 1, 0, 0);
    endtask

    task automatic t_reset;
        chk("R1 delay", delay_q, 0);
        chk("R1 valid", meas_valid, 0);
    endtask

    task automatic t_basic;
        tic_sel = 0;
        cyc(1, 0, 0, 1, 0, 0);        // tick with irq not counted
        ticks(5);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0);        // tick with tic not counted
        chk("R2 count", delay_q, 5);
        chk("R5 valid", meas_valid, 1);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R7 cleared", meas_valid, 0);
        chk("R7 value kept", delay_q, 5);
    endtask

    task automatic t_lone_tic;
        cyc(0, 1, 0, 0, 0, 0);
        chk("R4 delay", delay_q, 5);
        chk("R4 valid", meas_valid, 0);
    endtask

    task automatic t_ext_src;
        tic_sel = 1;
        cyc(1, 0, 0, 0, 0, 0);
        ticks(3);
        cyc(0, 1, 0, 0, 0, 0);        // deselected internal TIC
        chk("R3 int ignored", meas_valid, 0);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R3 ext capture", delay_q, 3);
        chk("R3 ext valid", meas_valid, 1);
    endtask

    task automatic t_protect;
        cyc(1, 0, 0, 1, 0, 0);
        ticks(4);
        cyc(0, 0, 1, 1, 0, 0);
        cyc(0, 1, 1, 0, 0, 0);
        chk("R6 delay", delay_q, 3);
        chk("R6 valid", meas_valid, 1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R8 flush", meas_valid, 0);
        chk("R8 value", delay_q, 3);
    endtask

    task automatic t_abort;
        tic_sel = 0;
        cyc(1, 0, 0, 0, 0, 0);
        ticks(2);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R8 abort valid", meas_valid, 0);
        chk("R8 abort delay", delay_q, 3);
    endtask

    task automatic t_rearm;
        cyc(1, 0, 0, 0, 0, 0);
        ticks(4);
        cyc(1, 0, 0, 1, 0, 0);
        ticks(2);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R10 restart", delay_q, 2);
        cyc(0, 0, 0, 0, 1, 0);
    endtask

    task automatic t_zero;
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0);
        chk("R2 zero", delay_q, 0);
        chk("R5 zero valid", meas_valid, 1);
        cyc(0, 0, 0, 0, 1, 0);
    endtask

    task automatic t_saturate;
        cyc(1, 0, 0, 0, 0, 0);
        ticks(70000);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R9 saturate", delay_q, 16'hFFFF);
        cyc(0, 0, 0, 0, 1, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_lone_tic();
        t_ext_src();
        t_protect();
        t_abort();
        t_rearm();
        t_zero();
        t_saturate();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule